// File: doc/BRIEF.md
# Converter Operating Mode Supervisor

This block is the sequencing state machine for a battery-fed switching converter and its two linear regulators. It looks at a set of digital flags produced by analog detectors: the shutdown inputs, a "battery voltage sufficient" flag, three output-level flags, two temperature flags and the present PWM/PFM operating mode. From these it decides which circuit may run: the independent start-up oscillator, the main digital switching controller, or neither. It also gates both linear regulators.

The normal path runs from shutdown to idle, then to start-up and then to regulation. A start-up begins once the battery is reported adequate. Control passes to the digital controller once the output is high enough to regulate. Two protective paths interrupt regulation. An output that sags below the regulation floor drops back to start-up, and an output below the absolute minimum stops all switching. An over-temperature flag, armed only while the controller runs in PWM mode, stops the converter and both regulators until a separate temperature-recovered flag is seen.

Every flag is asynchronous and passes through a synchroniser chain. The enables are registered, so with the default two-stage synchroniser a flag change reaches the enables on the fourth rising clock edge.

Top module: `pwr_mode_sup`

## Requirements
- R1: While `shdn_main` is high, `osc_en`, `ctrl_en` and `ldo1_en` are all 0 whatever the other flags are; `ldo2_en` is not affected by `shdn_main`.
- R2: After shutdown is released, no switching enable is set until `batt_ok` is high; with `batt_ok` high the start-up oscillator is enabled (`osc_en`=1, `ctrl_en`=0).
- R3: From start-up, `out_reg_ok` high hands control to the controller (`osc_en`=0, `ctrl_en`=1); `osc_en` and `ctrl_en` are never both 1.
- R4: During regulation, `out_below_floor` high returns the supervisor to start-up (`osc_en`=1, `ctrl_en`=0).
- R5: During regulation, `out_below_min` high stops all switching (`osc_en`=0, `ctrl_en`=0) and takes precedence over `out_below_floor`; `ldo1_en` stays 1.
- R6: From the stopped undervoltage state a restart happens only once `out_below_min` is low and `batt_ok` is high, and it always enters start-up first; toggling `batt_ok` while `out_below_min` is high has no effect.
- R7: During regulation with `pwm_mode`=1, `temp_hot` high clears `osc_en`, `ctrl_en`, `ldo1_en` and `ldo2_en`; with `pwm_mode`=0, `temp_hot` is ignored.
- R8: The thermal stop is left only when `temp_cool` goes high, not when `temp_hot` falls; it resumes through start-up, so on/off cycling is possible.
- R9: `ldo2_en` is 1 exactly when `shdn_ldo2` is low and no thermal stop is active; `ldo1_en` follows `shdn_main` and the thermal stop.
- R10: Under reset all four enables are 0. With the default two synchroniser stages, a flag that changes before rising edge 1 leaves the enables unchanged after edge 3 and shows its effect after edge 4.
- R11: In start-up, loss of `batt_ok` returns to idle and clears `osc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shdn_main | input | 1 | Shutdown of converter and first regulator, active high, asynchronous |
| shdn_ldo2 | input | 1 | Shutdown of second regulator, active high, asynchronous |
| batt_ok | input | 1 | Battery voltage adequate for start-up |
| out_reg_ok | input | 1 | Output high enough for normal regulation |
| out_below_floor | input | 1 | Output below the level where regulation is guaranteed |
| out_below_min | input | 1 | Output below the absolute minimum |
| temp_hot | input | 1 | Die temperature above the trip level |
| temp_cool | input | 1 | Die temperature below the recovery level |
| pwm_mode | input | 1 | Controller is in PWM (1) or PFM (0) mode |
| osc_en | output | 1 | Enable of the start-up oscillator |
| ctrl_en | output | 1 | Enable of the main digital controller |
| ldo1_en | output | 1 | Enable of the first linear regulator |
| ldo2_en | output | 1 | Enable of the second linear regulator |

## Verification
The sequencing is driven along each path in turn: normal power-up, a sag below the floor, a collapse below the minimum with the later recovery, and over-temperature. Over-temperature is applied once in PFM mode and once in PWM mode, which separates the armed trip from the ignored one. Releasing `temp_hot` without `temp_cool` separates a correct recovery threshold from a single-threshold one. Toggling `batt_ok` during the undervoltage stop shows whether the restart condition is checked correctly. Edge-exact sampling after a flag change shows whether the synchroniser depth and the output register are both present.

// File: rtl/pms_pkg.sv
package pms_pkg;

   typedef enum logic [2:0] {
      ST_SHDN   = 3'd0,
      ST_IDLE   = 3'd1,
      ST_START  = 3'd2,
      ST_REG    = 3'd3,
      ST_THERM  = 3'd4,
      ST_UVSTOP = 3'd5
   } pms_state_t;

   // bit positions inside the synchronised flag vector
   localparam int unsigned F_SHDN      = 0;
   localparam int unsigned F_LDO2_SHDN = 1;
   localparam int unsigned F_BATT      = 2;
   localparam int unsigned F_REGOK     = 3;
   localparam int unsigned F_FLOOR     = 4;
   localparam int unsigned F_MIN       = 5;
   localparam int unsigned F_HOT       = 6;
   localparam int unsigned F_COOL      = 7;
   localparam int unsigned F_PWM       = 8;
   localparam int unsigned FLAG_W      = 9;

   // both shutdown flags come out of reset asserted (safe side)
   localparam logic [FLAG_W-1:0] FLAG_RST = 9'b0_0000_0011;

endpackage

// File: rtl/pms_sync.sv
module pms_sync #(
   parameter int unsigned     W       = 1,
   parameter int unsigned     STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pms_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("pms_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
   import pms_pkg::*;
#(
   parameter bit THERM_PWM_ONLY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] flg,
   output pms_state_t        st_q
);

   logic therm_trip;
   pms_state_t st_d;

   // thermal trip arming: PWM-only or always
   if (THERM_PWM_ONLY) begin : g_trip_pwm
      assign therm_trip = flg[F_HOT] & flg[F_PWM];
   end else begin : g_trip_any
      assign therm_trip = flg[F_HOT];
   end

   always_comb begin
      st_d = st_q;
      if (flg[F_SHDN]) begin
         st_d = ST_SHDN;
      end else begin
         unique case (st_q)
            ST_SHDN:   st_d = ST_IDLE;
            ST_IDLE:   if (flg[F_BATT]) st_d = ST_START;
            ST_START: begin
               if (!flg[F_BATT])      st_d = ST_IDLE;
               else if (flg[F_REGOK]) st_d = ST_REG;
            end
            ST_REG: begin
               if (flg[F_MIN])        st_d = ST_UVSTOP;
               else if (flg[F_FLOOR]) st_d = ST_START;
               else if (therm_trip)   st_d = ST_THERM;
            end
            ST_THERM:  if (flg[F_COOL]) st_d = ST_START;
            ST_UVSTOP: if (!flg[F_MIN] && flg[F_BATT]) st_d = ST_START;
            default:   st_d = ST_SHDN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_SHDN;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/pms_outdec.sv
module pms_outdec
   import pms_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  pms_state_t st_q,
   input  logic       ldo2_shdn_s,
   output logic       osc_en,
   output logic       ctrl_en,
   output logic       ldo1_en,
   output logic       ldo2_en
);

   logic osc_d, ctrl_d, ldo1_d, ldo2_d;

   always_comb begin
      osc_d  = (st_q == ST_START);
      ctrl_d = (st_q == ST_REG);
      ldo1_d = (st_q != ST_SHDN) && (st_q != ST_THERM);
      ldo2_d = !ldo2_shdn_s && (st_q != ST_THERM);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osc_en  <= 1'b0;
         ctrl_en <= 1'b0;
         ldo1_en <= 1'b0;
         ldo2_en <= 1'b0;
      end else begin
         osc_en  <= osc_d;
         ctrl_en <= ctrl_d;
         ldo1_en <= ldo1_d;
         ldo2_en <= ldo2_d;
      end
   end

endmodule

// File: rtl/pwr_mode_sup.sv
module pwr_mode_sup
   import pms_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          THERM_PWM_ONLY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shdn_main,
   input  logic shdn_ldo2,
   input  logic batt_ok,
   input  logic out_reg_ok,
   input  logic out_below_floor,
   input  logic out_below_min,
   input  logic temp_hot,
   input  logic temp_cool,
   input  logic pwm_mode,
   output logic osc_en,
   output logic ctrl_en,
   output logic ldo1_en,
   output logic ldo2_en
);

   logic [FLAG_W-1:0] flg_raw;
   logic [FLAG_W-1:0] flg_s;
   logic              shdn_s;
   pms_state_t        st_q;

   always_comb begin
      flg_raw              = '0;
      flg_raw[F_SHDN]      = shdn_main;
      flg_raw[F_LDO2_SHDN] = shdn_ldo2;
      flg_raw[F_BATT]      = batt_ok;
      flg_raw[F_REGOK]     = out_reg_ok;
      flg_raw[F_FLOOR]     = out_below_floor;
      flg_raw[F_MIN]       = out_below_min;
      flg_raw[F_HOT]       = temp_hot;
      flg_raw[F_COOL]      = temp_cool;
      flg_raw[F_PWM]       = pwm_mode;
   end

   pms_sync #(
      .W       (FLAG_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (FLAG_RST)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (flg_raw),
      .q     (flg_s)
   );

   assign shdn_s = flg_s[F_SHDN];

   pms_fsm #(
      .THERM_PWM_ONLY (THERM_PWM_ONLY)
   ) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .flg   (flg_s),
      .st_q  (st_q)
   );

   pms_outdec u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .st_q        (st_q),
      .ldo2_shdn_s (flg_s[F_LDO2_SHDN]),
      .osc_en      (osc_en),
      .ctrl_en     (ctrl_en),
      .ldo1_en     (ldo1_en),
      .ldo2_en     (ldo2_en)
   );

endmodule

// File: rtl/pms_chk.sv
module pms_chk
   import pms_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       shdn_s,
   input pms_state_t st_q,
   input logic       osc_en,
   input logic       ctrl_en,
   input logic       ldo1_en,
   input logic       ldo2_en
);

   assert_shdn_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      shdn_s |=> ##1 (!osc_en && !ctrl_en && !ldo1_en))
      else $error("shutdown did not clear converter enables");

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |=> (!osc_en && !ctrl_en))
      else $error("switching enabled while idle");

   assert_single_driver_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(osc_en && ctrl_en))
      else $error("oscillator and controller enabled together");

   assert_uv_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_UVSTOP) |=> (!osc_en && !ctrl_en && ldo1_en))
      else $error("undervoltage stop enables wrong");

   assert_uv_exit_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == ST_UVSTOP && st_q != ST_UVSTOP) |-> (st_q == ST_START || st_q == ST_SHDN))
      else $error("undervoltage stop left without start-up");

   assert_therm_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_THERM) |=> (!osc_en && !ctrl_en && !ldo1_en && !ldo2_en))
      else $error("thermal stop left an enable set");

   assert_therm_exit_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == ST_THERM && st_q != ST_THERM) |-> (st_q == ST_START || st_q == ST_SHDN))
      else $error("thermal stop left without start-up");

endmodule

bind pwr_mode_sup pms_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .shdn_s  (shdn_s),
   .st_q    (st_q),
   .osc_en  (osc_en),
   .ctrl_en (ctrl_en),
   .ldo1_en (ldo1_en),
   .ldo2_en (ldo2_en)
);

// File: tb/pwr_mode_sup_tb.sv
module pwr_mode_sup_tb;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic shdn_main = 1'b1;
   logic shdn_ldo2 = 1'b1;
   logic batt_ok = 1'b0;
   logic out_reg_ok = 1'b0;
   logic out_below_floor = 1'b0;
   logic out_below_min = 1'b0;
   logic temp_hot = 1'b0;
   logic temp_cool = 1'b0;
   logic pwm_mode = 1'b0;
   logic osc_en, ctrl_en, ldo1_en, ldo2_en;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_sup u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .shdn_main       (shdn_main),
      .shdn_ldo2       (shdn_ldo2),
      .batt_ok         (batt_ok),
      .out_reg_ok      (out_reg_ok),
      .out_below_floor (out_below_floor),
      .out_below_min   (out_below_min),
      .temp_hot        (temp_hot),
      .temp_cool       (temp_cool),
      .pwm_mode        (pwm_mode),
      .osc_en          (osc_en),
      .ctrl_en         (ctrl_en),
      .ldo1_en         (ldo1_en),
      .ldo2_en         (ldo2_en)
   );

   task automatic chk(input string req, input logic [3:0] exp);
      logic [3:0] got;
      got = {osc_en, ctrl_en, ldo1_en, ldo2_en};
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s {osc,ctrl,ldo1,ldo2} actual=%b expected=%b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic settle();
      repeat (SETTLE) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk("R10 reset", 4'b0000);
      rst_n = 1'b1;
      settle();
      chk("R1 held in shutdown", 4'b0000);
   endtask

   task automatic t_idle();
      shdn_main = 1'b0;
      settle();
      chk("R2 idle without battery", 4'b0010);
   endtask

   task automatic t_latency();
      batt_ok = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10 no change after edge 3", 4'b0010);
      @(posedge clk);
      @(negedge clk);
      chk("R10 change after edge 4", 4'b1010);
      chk("R2 start-up oscillator on", 4'b1010);
   endtask

   task automatic t_batt_loss();
      batt_ok = 1'b0;
      settle();
      chk("R11 battery loss in start-up", 4'b0010);
      batt_ok = 1'b1;
      settle();
      chk("R2 start-up again", 4'b1010);
   endtask

   task automatic t_regulate();
      out_reg_ok = 1'b1;
      settle();
      chk("R3 handover to controller", 4'b0110);
   endtask

   task automatic t_floor();
      out_reg_ok = 1'b0;
      out_below_floor = 1'b1;
      settle();
      chk("R4 floor returns to start-up", 4'b1010);
      out_below_floor = 1'b0;
      out_reg_ok = 1'b1;
      settle();
      chk("R3 regulation regained", 4'b0110);
   endtask

   task automatic t_uv();
      out_reg_ok = 1'b0;
      out_below_floor = 1'b1;
      out_below_min = 1'b1;
      settle();
      chk("R5 undervoltage stop", 4'b0010);
      batt_ok = 1'b0;
      settle();
      batt_ok = 1'b1;
      settle();
      chk("R6 no restart while below minimum", 4'b0010);
      out_below_min = 1'b0;
      settle();
      chk("R6 restart through start-up", 4'b1010);
      out_below_floor = 1'b0;
      out_reg_ok = 1'b1;
      settle();
      chk("R3 regulation after recovery", 4'b0110);
   endtask

   task automatic t_therm();
      shdn_ldo2 = 1'b0;
      settle();
      chk("R9 second regulator on", 4'b0111);
      pwm_mode = 1'b0;
      temp_hot = 1'b1;
      settle();
      chk("R7 hot ignored in PFM", 4'b0111);
      pwm_mode = 1'b1;
      settle();
      chk("R7 thermal stop in PWM", 4'b0000);
      temp_hot = 1'b0;
      settle();
      chk("R8 hot release alone does not resume", 4'b0000);
      temp_cool = 1'b1;
      settle();
      chk("R8 resume on recovery flag", 4'b0111);
      temp_cool = 1'b0;
      settle();
   endtask

   task automatic t_ldo2_indep();
      shdn_main = 1'b1;
      temp_hot = 1'b1;
      settle();
      chk("R1 shutdown overrides, LDO2 kept", 4'b0001);
      shdn_ldo2 = 1'b1;
      settle();
      chk("R9 LDO2 own shutdown", 4'b0000);
      temp_hot = 1'b0;
      shdn_main = 1'b0;
      settle();
      chk("R3 power-up to regulation", 4'b0110);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_latency();
      t_batt_loss();
      t_regulate();
      t_floor();
      t_uv();
      t_therm();
      t_ldo2_indep();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule